// File: doc/BRIEF.md
# Serial Configuration Bitstream Frame Parser

This block watches a serial configuration stream, one bit per clock qualified by a valid strobe, and recovers its structure. It first waits for a run of dummy ones and a four-bit preamble. It then takes a 24-bit length field and a run of trailing ones. After that it splits the rest of the stream into frames. The first frame may be an identification frame, which carries a parity-enable bit, a reserved zero field and a 20-bit part identifier. The frames after it are data frames, either uncompressed (address plus payload) or compressed (address only). A dedicated 16-bit terminator closes the stream.

For each completed frame the parser raises a one-cycle completion pulse. With it come a frame-type code, the column address, and the payload held in a shift register. If parity checking is enabled, it also reports a per-frame parity error. Grammar violations set a sticky format-error flag, and the parser then resynchronises on the next frame start. Writing the payload into configuration memory is left to downstream logic.

Top module: `cfg_stream_parser`

## Requirements
- R1: The header is recognised only after at least 4 consecutive ones followed by the bits 0,0,1,0; fewer ones cause no error and the search simply continues. The next 24 bits are the length, most significant bit first; one cycle after the last of them `len_vld_o` rises and stays high, with `len_o` holding the length.
- R2: After the length, at least 4 ones must precede the first frame-start 0; a 0 after fewer ones sets `fmt_err_o`.
- R3: A frame is start 0, P, C, Opar, Epar and an 11-bit address (MSB first). The first frame after the header with P=1, C=0 and an all-ones address is the ID frame: a parity-enable bit, 43 reserved bits and a 20-bit ID (MSB first) follow. After its last ID bit, `frame_done_o` pulses with `frm_type_o`=1, `id_o` holds the ID, `id_vld_o` is high and `par_en_o` holds the enable bit.
- R4: A reserved bit of 1 in the ID frame sets `fmt_err_o`; the flag stays high until reset and the parser waits for a 1 and then a 0 to start the next frame.
- R5: An uncompressed data frame (P=1, C=0, not the ID frame) carries ALIGN_BITS zeros, a write bit of 1 and DATA_BITS payload bits MSB first. After the last payload bit, `frame_done_o` pulses with `frm_type_o`=2, `addr_o` holds the address and `data_o` the payload.
- R6: A compressed data frame (P=1, C=1) ends with its address: `frame_done_o` pulses with `frm_type_o`=3 and `addr_o` holding the address.
- R7: At least 3 ones must follow the ID frame and at least 1 must follow a data frame before the next start 0; fewer set `fmt_err_o`.
- R8: With parity enabled, the frame bits from the first address bit onward are indexed from 0. Opar must make the count of ones among the odd-indexed bits plus Opar odd. Epar must make the count among the even-indexed bits plus Epar even. A mismatch raises `par_err_o` together with that frame's completion pulse. With parity disabled, `par_err_o` stays 0.
- R9: A frame with P=0 must be the terminator 0010011111111111; on its last bit `frame_done_o` pulses with `frm_type_o`=4, and any number of ones may follow.
- R10: A cycle with `in_vld_i` low consumes no bit: no output changes in the next cycle and no frame completes.
- R11: After reset all outputs are 0 and `frm_type_o` is 0 (no frame).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld_i | input | 1 | Stream bit valid |
| in_bit_i | input | 1 | Stream bit |
| frame_done_o | output | 1 | One-cycle pulse when a frame completes |
| frm_type_o | output | 3 | 0 none, 1 ID, 2 uncompressed data, 3 compressed data, 4 terminator |
| addr_o | output | ADDR_W | Column address of the latest data frame |
| data_o | output | DATA_BITS | Payload shift register |
| len_o | output | LEN_W | Captured length field |
| len_vld_o | output | 1 | Length has been captured |
| id_o | output | ID_W | Part identifier |
| id_vld_o | output | 1 | Part identifier has been captured |
| par_en_o | output | 1 | Parity checking enabled by the ID frame |
| par_err_o | output | 1 | Parity mismatch for the completing frame |
| fmt_err_o | output | 1 | Sticky format-error flag |

## Verification
The bench builds the parser with 2 alignment zeros and a 16-bit payload, so an uncompressed frame lasts about 35 bits. Many frames can therefore run back to back in a short test, including frames with an all-ones address after the ID frame, payloads of all ones, and compressed frames with corrupted parity. The small sizes also leave room for separate runs, each covering one way the grammar can fail: a short trailing run, a missing stop after the ID frame, and a nonzero reserved bit. Each of these runs is followed by a clean frame that shows the parser has resynchronised.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [2:0] {
    FT_NONE = 3'd0,
    FT_ID   = 3'd1,
    FT_DATA = 3'd2,
    FT_COMP = 3'd3,
    FT_END  = 3'd4
  } frm_t;

  typedef enum logic [4:0] {
    S_LEAD, S_PRE, S_LEN, S_TRAIL, S_SEEK,
    S_CTLP, S_CTLC, S_OPAR, S_EPAR, S_ADDR,
    S_PEN, S_RSV, S_ID, S_ALIGN, S_WBIT,
    S_DATA, S_STOP, S_END, S_POST
  } pst_t;
endpackage

// File: rtl/cfgp_shreg.sv
module cfgp_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  generate
    if (W == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= {q[W-2:0], din};
      end
    end
  endgenerate
endmodule

// File: rtl/cfgp_parity.sv
module cfgp_parity (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic din,
  output logic fin_odd,
  output logic fin_even
);
  logic ph, xo, xe;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ph <= 1'b0;
      xo <= 1'b0;
      xe <= 1'b0;
    end else if (en) begin
      if (ph) xo <= xo ^ din;
      else    xe <= xe ^ din;
      ph <= ~ph;
    end
  end

  assign fin_odd  = xo ^ (en & ph & din);
  assign fin_even = xe ^ (en & ~ph & din);
endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser #(
  parameter int ALIGN_BITS = 2,
  parameter int DATA_BITS  = 16,
  parameter int ADDR_W     = 11,
  parameter int LEN_W      = 24,
  parameter int ID_W       = 20,
  parameter int RSV_BITS   = 43
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld_i,
  input  logic                 in_bit_i,
  output logic                 frame_done_o,
  output logic [2:0]           frm_type_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic [LEN_W-1:0]     len_o,
  output logic                 len_vld_o,
  output logic [ID_W-1:0]      id_o,
  output logic                 id_vld_o,
  output logic                 par_en_o,
  output logic                 par_err_o,
  output logic                 fmt_err_o
);
  import cfgp_pkg::*;

  localparam int M1   = (RSV_BITS > DATA_BITS) ? RSV_BITS : DATA_BITS;
  localparam int M2   = (LEN_W > ID_W) ? LEN_W : ID_W;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int M4   = (ADDR_W > ALIGN_BITS) ? ADDR_W : ALIGN_BITS;
  localparam int MAXC = (M3 > M4) ? M3 : M4;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int TAIL = 13;

  pst_t         st;
  logic [CW-1:0] cnt;
  logic [2:0]   run;
  logic         need3, first_frm, p_r, c_r, opar_r, epar_r;
  logic         done_r, perr_r, ferr_r, lenv_r, idv_r, pen_r;
  frm_t         type_r;

  logic [2:0]        run_nx;
  logic [ADDR_W-1:0] addr_full;
  logic              fin_odd, fin_even, par_mis, par_en_acc;

  assign run_nx    = (run == 3'd4) ? run : run + 3'd1;
  assign addr_full = {addr_o[ADDR_W-2:0], in_bit_i};
  assign par_en_acc = in_vld_i && (st == S_ADDR || st == S_ALIGN ||
                                   st == S_WBIT || st == S_DATA);
  assign par_mis   = ~(fin_odd ^ opar_r) | (fin_even ^ epar_r);

  cfgp_shreg #(.W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .en(in_vld_i && st == S_LEN), .din(in_bit_i), .q(len_o));
  cfgp_shreg #(.W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .en(in_vld_i && st == S_ADDR), .din(in_bit_i), .q(addr_o));
  cfgp_shreg #(.W(ID_W)) u_id (
    .clk(clk), .rst(rst), .en(in_vld_i && st == S_ID), .din(in_bit_i), .q(id_o));
  cfgp_shreg #(.W(DATA_BITS)) u_data (
    .clk(clk), .rst(rst), .en(in_vld_i && st == S_DATA), .din(in_bit_i), .q(data_o));

  cfgp_parity u_par (
    .clk(clk), .rst(rst), .clr(in_vld_i && st == S_CTLP), .en(par_en_acc),
    .din(in_bit_i), .fin_odd(fin_odd), .fin_even(fin_even));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_LEAD;  cnt <= '0;  run <= '0;
      need3 <= 1'b0; first_frm <= 1'b0;
      p_r <= 1'b0;   c_r <= 1'b0;  opar_r <= 1'b0; epar_r <= 1'b0;
      done_r <= 1'b0; perr_r <= 1'b0; ferr_r <= 1'b0;
      lenv_r <= 1'b0; idv_r <= 1'b0;  pen_r <= 1'b0;
      type_r <= FT_NONE;
    end else begin
      done_r <= 1'b0;
      perr_r <= 1'b0;
      if (in_vld_i) begin
        unique case (st)
          S_LEAD: begin
            if (in_bit_i) run <= run_nx;
            else if (run == 3'd4) begin st <= S_PRE; cnt <= '0; end
            else run <= '0;
          end
          S_PRE: begin
            if (in_bit_i != (cnt == CW'(1))) begin
              ferr_r <= 1'b1; st <= S_LEAD; run <= '0;
            end else if (cnt == CW'(2)) begin st <= S_LEN; cnt <= '0; end
            else cnt <= cnt + CW'(1);
          end
          S_LEN: begin
            if (cnt == CW'(LEN_W - 1)) begin
              st <= S_TRAIL; run <= '0; lenv_r <= 1'b1;
            end else cnt <= cnt + CW'(1);
          end
          S_TRAIL: begin
            if (in_bit_i) run <= run_nx;
            else if (run == 3'd4) begin st <= S_CTLP; first_frm <= 1'b1; end
            else begin ferr_r <= 1'b1; st <= S_SEEK; run <= '0; end
          end
          S_SEEK: begin
            if (in_bit_i) run <= 3'd1;
            else if (run != 3'd0) st <= S_CTLP;
          end
          S_CTLP: begin p_r <= in_bit_i; st <= S_CTLC; end
          S_CTLC: begin
            c_r <= in_bit_i;
            if (p_r) st <= S_OPAR;
            else if (in_bit_i) begin st <= S_END; cnt <= '0; end
            else begin ferr_r <= 1'b1; st <= S_SEEK; run <= '0; end
          end
          S_OPAR: begin opar_r <= in_bit_i; st <= S_EPAR; end
          S_EPAR: begin epar_r <= in_bit_i; st <= S_ADDR; cnt <= '0; end
          S_ADDR: begin
            if (cnt == CW'(ADDR_W - 1)) begin
              first_frm <= 1'b0;
              cnt <= '0;
              if (first_frm && !c_r && (&addr_full)) st <= S_PEN;
              else if (c_r) begin
                done_r <= 1'b1; type_r <= FT_COMP; perr_r <= pen_r & par_mis;
                st <= S_STOP; need3 <= 1'b0; run <= '0;
              end else st <= (ALIGN_BITS > 0) ? S_ALIGN : S_WBIT;
            end else cnt <= cnt + CW'(1);
          end
          S_PEN: begin pen_r <= in_bit_i; st <= S_RSV; cnt <= '0; end
          S_RSV: begin
            if (in_bit_i) begin ferr_r <= 1'b1; st <= S_SEEK; run <= '0; end
            else if (cnt == CW'(RSV_BITS - 1)) begin st <= S_ID; cnt <= '0; end
            else cnt <= cnt + CW'(1);
          end
          S_ID: begin
            if (cnt == CW'(ID_W - 1)) begin
              idv_r <= 1'b1; done_r <= 1'b1; type_r <= FT_ID;
              st <= S_STOP; need3 <= 1'b1; run <= '0;
            end else cnt <= cnt + CW'(1);
          end
          S_ALIGN: begin
            if (in_bit_i) begin ferr_r <= 1'b1; st <= S_SEEK; run <= '0; end
            else if (cnt == CW'(ALIGN_BITS - 1)) st <= S_WBIT;
            else cnt <= cnt + CW'(1);
          end
          S_WBIT: begin
            if (!in_bit_i) begin ferr_r <= 1'b1; st <= S_SEEK; run <= '0; end
            else begin st <= S_DATA; cnt <= '0; end
          end
          S_DATA: begin
            if (cnt == CW'(DATA_BITS - 1)) begin
              done_r <= 1'b1; type_r <= FT_DATA; perr_r <= pen_r & par_mis;
              st <= S_STOP; need3 <= 1'b0; run <= '0;
            end else cnt <= cnt + CW'(1);
          end
          S_STOP: begin
            if (in_bit_i) run <= run_nx;
            else if (run >= (need3 ? 3'd3 : 3'd1)) st <= S_CTLP;
            else begin ferr_r <= 1'b1; st <= S_SEEK; run <= '0; end
          end
          S_END: begin
            if (in_bit_i != (cnt >= CW'(2))) begin
              ferr_r <= 1'b1; st <= S_SEEK; run <= '0;
            end else if (cnt == CW'(TAIL - 1)) begin
              done_r <= 1'b1; type_r <= FT_END; st <= S_POST;
            end else cnt <= cnt + CW'(1);
          end
          S_POST: begin
            if (!in_bit_i) begin ferr_r <= 1'b1; st <= S_LEAD; run <= '0; end
          end
          default: st <= S_LEAD;
        endcase
      end
    end
  end

  assign frame_done_o = done_r;
  assign frm_type_o   = type_r;
  assign len_vld_o    = lenv_r;
  assign id_vld_o     = idv_r;
  assign par_en_o     = pen_r;
  assign par_err_o    = perr_r;
  assign fmt_err_o    = ferr_r;
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_vld_i,
  input logic       frame_done_o,
  input logic [2:0] frm_type_o,
  input logic       len_vld_o,
  input logic       id_vld_o,
  input logic       par_en_o,
  input logic       par_err_o,
  input logic       fmt_err_o
);
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    !in_vld_i |=> !frame_done_o); // R10
  AST_FMT_STICKY: assert property (@(posedge clk) disable iff (rst)
    fmt_err_o |=> fmt_err_o); // R4
  AST_PERR_ON_DATA: assert property (@(posedge clk) disable iff (rst)
    par_err_o |-> frame_done_o && (frm_type_o == 3'd2 || frm_type_o == 3'd3)); // R8
  AST_PERR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    par_err_o |-> par_en_o); // R8
  AST_DONE_TYPED: assert property (@(posedge clk) disable iff (rst)
    frame_done_o |-> frm_type_o != 3'd0); // R5
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
    len_vld_o |=> len_vld_o); // R1
  AST_ID_VALID: assert property (@(posedge clk) disable iff (rst)
    (frame_done_o && frm_type_o == 3'd1) |-> id_vld_o); // R3
endmodule

bind cfg_stream_parser cfgp_checker u_cfgp_checker (
  .clk(clk), .rst(rst), .in_vld_i(in_vld_i), .frame_done_o(frame_done_o),
  .frm_type_o(frm_type_o), .len_vld_o(len_vld_o), .id_vld_o(id_vld_o),
  .par_en_o(par_en_o), .par_err_o(par_err_o), .fmt_err_o(fmt_err_o));

// File: tb/test_cfg_stream_parser.sv
module test_cfg_stream_parser;
  localparam int AW = 11, DW = 16, LW = 24, IW = 20, AB = 2;

  logic clk = 1'b0, rst = 1'b1, in_vld = 1'b0, in_bit = 1'b0;
  logic          frame_done, len_vld, id_vld, par_en, par_err, fmt_err;
  logic [2:0]    frm_type;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic [LW-1:0] len;
  logic [IW-1:0] id;

  cfg_stream_parser #(.ALIGN_BITS(AB), .DATA_BITS(DW)) i_cfg_stream_parser (
    .clk(clk), .rst(rst), .in_vld_i(in_vld), .in_bit_i(in_bit),
    .frame_done_o(frame_done), .frm_type_o(frm_type), .addr_o(addr),
    .data_o(data), .len_o(len), .len_vld_o(len_vld), .id_o(id),
    .id_vld_o(id_vld), .par_en_o(par_en), .par_err_o(par_err),
    .fmt_err_o(fmt_err));

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0, gapc = 0;
  bit q_bit[$];
  int q_mark[$];
  int ev_type[$], ev_addr[$], ev_id[$];
  logic [DW-1:0] ev_data[$];
  bit ev_perr[$], ev_pen[$];
  bit cur_pen, exp_fmt, exp_lenv;
  logic [LW-1:0] exp_len;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input bit b, input int m = -1);
    q_bit.push_back(b);
    q_mark.push_back(m);
  endtask

  task automatic push_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) push(v[i]);
  endtask

  task automatic mark_last(input int m);
    q_mark[q_mark.size() - 1] = m;
  endtask

  function automatic int add_ev(input int t, input int a, input logic [DW-1:0] d,
                                input bit pe, input int i, input bit pn);
    ev_type.push_back(t); ev_addr.push_back(a); ev_data.push_back(d);
    ev_perr.push_back(pe); ev_id.push_back(i); ev_pen.push_back(pn);
    return ev_type.size() - 1;
  endfunction

  task automatic hdr(input int lead, input logic [LW-1:0] l, input int trail);
    repeat (lead) push(1'b1);
    push(0); push(0); push(1); push(0);
    push_bits(64'(l), LW);
    mark_last(-3);
    exp_len = l;
    repeat (trail) push(1'b1);
  endtask

  task automatic stops(input int n);
    repeat (n) push(1'b1);
  endtask

  task automatic id_frame(input bit pn, input bit bad, input logic [IW-1:0] idv);
    push(0); push(1); push(0); push(0); push(0);
    push_bits(64'h7FF, AW);
    push(pn);
    cur_pen = pn;
    if (bad) begin
      repeat (5) push(0);
      push(1, -2);
      return;
    end
    repeat (43) push(0);
    push_bits(64'(idv), IW);
    mark_last(add_ev(1, 0, '0, 1'b0, int'(idv), pn));
  endtask

  task automatic data_frame(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit comp, input bit flip);
    bit body[$];
    bit xo, xe;
    for (int i = AW - 1; i >= 0; i--) body.push_back(a[i]);
    if (!comp) begin
      repeat (AB) body.push_back(1'b0);
      body.push_back(1'b1);
      for (int i = DW - 1; i >= 0; i--) body.push_back(d[i]);
    end
    xo = 0; xe = 0;
    foreach (body[j]) if (j % 2) xo ^= body[j]; else xe ^= body[j];
    push(0); push(1); push(comp);
    push(~xo ^ flip); push(xe);
    foreach (body[j]) push(body[j]);
    mark_last(add_ev(comp ? 3 : 2, int'(a), d, flip & cur_pen, 0, cur_pen));
  endtask

  task automatic end_word();
    push_bits(64'h27FF, 16);
    mark_last(add_ev(4, 0, '0, 1'b0, 0, cur_pen));
  endtask

  task automatic check_cycle(input int m);
    string rq;
    if (m == -2) exp_fmt = 1'b1;
    if (m == -3) exp_lenv = 1'b1;
    chk(fmt_err == exp_fmt, "R2 R4 R7", "fmt_err", fmt_err, exp_fmt);
    chk(len_vld == exp_lenv, "R1", "len_vld", len_vld, exp_lenv);
    if (exp_lenv) chk(len == exp_len, "R1", "len", len, exp_len);
    if (m < 0) begin
      chk(frame_done == 1'b0, "R10", "frame_done", frame_done, 0);
      chk(par_err == 1'b0, "R8", "par_err idle", par_err, 0);
    end else begin
      case (ev_type[m])
        1: rq = "R3";
        2: rq = "R5";
        3: rq = "R6";
        default: rq = "R9";
      endcase
      chk(frame_done == 1'b1, rq, "frame_done", frame_done, 1);
      chk(int'(frm_type) == ev_type[m], rq, "frm_type", frm_type, ev_type[m]);
      chk(par_err == ev_perr[m], "R8", "par_err", par_err, ev_perr[m]);
      if (ev_type[m] == 2 || ev_type[m] == 3)
        chk(int'(addr) == ev_addr[m], rq, "addr", addr, ev_addr[m]);
      if (ev_type[m] == 2)
        chk(data == ev_data[m], rq, "data", data, ev_data[m]);
      if (ev_type[m] == 1) begin
        chk(int'(id) == ev_id[m], "R3", "id", id, ev_id[m]);
        chk(id_vld == 1'b1, "R3", "id_vld", id_vld, 1);
        chk(par_en == ev_pen[m], "R3", "par_en", par_en, ev_pen[m]);
      end
    end
  endtask

  task automatic run_stream();
    int prev = -1;
    while (q_bit.size() > 0) begin
      @(negedge clk);
      check_cycle(prev);
      gapc++;
      if (gapc % 7 == 0) begin
        in_vld = 1'b0; in_bit = ~in_bit; prev = -1;
      end else begin
        in_vld = 1'b1; in_bit = q_bit.pop_front(); prev = q_mark.pop_front();
      end
    end
    @(negedge clk);
    check_cycle(prev);
    in_vld = 1'b0;
    @(negedge clk);
    check_cycle(-1);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_vld = 1'b0;
    repeat (3) @(negedge clk);
    chk(frame_done == 0 && par_err == 0 && fmt_err == 0, "R11", "pulses/flags",
        {frame_done, par_err, fmt_err}, 0);
    chk(len_vld == 0 && id_vld == 0 && par_en == 0, "R11", "valids",
        {len_vld, id_vld, par_en}, 0);
    chk(frm_type == 3'd0 && addr == '0 && data == '0, "R11", "type/addr/data",
        frm_type, 0);
    rst = 1'b0;
    exp_fmt = 0; exp_lenv = 0; exp_len = '0; cur_pen = 0;
    q_bit.delete(); q_mark.delete();
    ev_type.delete(); ev_addr.delete(); ev_data.delete();
    ev_perr.delete(); ev_id.delete(); ev_pen.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // full stream, parity enabled (R1 R3 R5 R6 R8 R9)
    do_reset();
    hdr(6, 24'hABCDE1, 4);
    id_frame(1, 0, 20'h5A3C1); stops(3);
    data_frame(11'h012, 16'hBEEF, 0, 0); stops(1);
    data_frame(11'h3F0, '0, 1, 0); stops(2);
    data_frame(11'h7FE, 16'h1234, 0, 1); stops(1);
    data_frame(11'h7FF, 16'h00A5, 0, 0); stops(1);
    data_frame(11'h005, 16'hFFFF, 0, 0); stops(1);
    data_frame(11'h2A1, '0, 1, 1); stops(1);
    end_word(); stops(5);
    run_stream();

    // parity disabled by ID frame: bad parity ignored (R8)
    do_reset();
    hdr(4, 24'h000010, 4);
    id_frame(0, 0, 20'h00F0F); stops(4);
    data_frame(11'h100, 16'h8001, 0, 1); stops(1);
    end_word();
    run_stream();

    // no ID frame at all (R5 R9)
    do_reset();
    hdr(4, 24'h800001, 5);
    data_frame(11'h2AA, 16'h0F0F, 0, 1); stops(1);
    end_word();
    run_stream();

    // nonzero reserved bit then recovery (R4)
    do_reset();
    hdr(4, 24'h000123, 4);
    id_frame(0, 1, '0);
    push(1);
    data_frame(11'h012, 16'h5555, 0, 0); stops(1);
    run_stream();

    // short trailing run (R2)
    do_reset();
    hdr(4, 24'h0F0F0F, 2);
    push(0, -2); push(1);
    data_frame(11'h00C, 16'hC3C3, 0, 0); stops(1);
    run_stream();

    // missing stop bits after ID frame (R7)
    do_reset();
    hdr(4, 24'h000001, 4);
    id_frame(1, 0, 20'hFFFFF); stops(2);
    push(0, -2); push(1);
    data_frame(11'h444, 16'h2468, 0, 0); stops(1);
    run_stream();

    // too few leading ones: ignored, then valid header (R1)
    do_reset();
    push(1); push(1); push(1); push(0); push(0); push(1); push(0);
    hdr(5, 24'h00BEAD, 4);
    data_frame(11'h001, '0, 1, 0); stops(1);
    run_stream();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule